// File: doc/BRIEF.md
# Warp Issue Scheduler with Memory-Latency Hiding

This block sits in front of one multiprocessor's execution lanes and owns a pool of resident warp slots. In every cycle it chooses at most one warp that is able to run and presents that warp's index on the issue outputs. The execution side reports what kind of instruction each warp holds next through a per-warp hint. A warp whose issued instruction is a memory access is then held back for a programmable number of cycles, and the scheduler moves on to the other resident warps. This keeps the lanes busy while memory replies are outstanding.

Warps are placed into slots and removed from them through a single activate port and a single retire port. The block reports how many slots are currently occupied, so the occupancy ratio is that count divided by the slot total. It raises a stall flag only when warps are present but none of them can issue. Decoding, execution and the memory system are outside the block.

Top module: `warp_issue_sched`

## Requirements
- R1: In each cycle at most one warp is issued (`issue_valid`=1 with its index on `issue_id`). The warp must be resident, have no memory wait pending, and must not be retiring in that same cycle. `issue_id` reads 0 when nothing is issued.
- R2: The chosen warp is the first eligible slot found by a circular search that starts at the slot after the most recently issued warp. After reset the search starts at slot 0.
- R3: When the hint bit `kind_mem[w]` is 1 (memory) in the cycle warp `w` is issued at cycle t, that warp is not issued again before cycle t+MEM_LAT+1. Unless something else intervenes, it is eligible again from cycle t+MEM_LAT+1.
- R4: When the hint bit is 0 (ALU) at issue, the warp remains eligible in the very next cycle.
- R5: `stall` is 1 exactly when at least one slot is occupied (`occupancy`≠0) and no warp is issued in that cycle. An empty pool gives `stall`=0.
- R6: `occupancy` equals the number of occupied slots. It reflects an activate or retire from the following cycle onward.
- R7: Activating an empty slot makes it resident and eligible from the next cycle. Activating a slot that is already resident has no effect, and any memory wait on it continues.
- R8: A retired warp is excluded from issue in the cycle of the retire and is no longer resident afterwards. Retiring an empty slot changes nothing.
- R9: If activate and retire name the same slot in the same cycle, the retire takes effect and the activate is dropped.
- R10: During and right after reset no slot is resident, and `issue_valid`, `stall` and `occupancy` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Place a warp into slot `act_id` |
| act_id | input | IDW | Slot index to activate |
| ret_valid | input | 1 | Remove the warp in slot `ret_id` |
| ret_id | input | IDW | Slot index to retire |
| kind_mem | input | NUM_WARPS | Per-warp hint for the next instruction: 1 = memory, 0 = ALU |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_id | output | IDW | Index of the issued warp |
| stall | output | 1 | Warps are present but none can issue |
| occupancy | output | OCW | Number of occupied slots |

## Verification
The issue outputs and `stall` are combinational from the registered slot state and the same-cycle retire request. They are therefore sampled in the same cycle as the stimulus that shapes them, just before the next rising edge. An activate or retire changes eligibility and `occupancy` one edge later. A memory issue at cycle t keeps that warp out of the search until cycle t+MEM_LAT+1. The bench's scoreboard model advances its slot state only after it has queued the expectation for the current cycle. Each entry is then compared against the outputs one nanosecond after the inputs are driven on the falling edge, so every result is checked in the cycle in which it is due.

// File: rtl/wis_pkg.sv
package wis_pkg;

    typedef enum logic {
        HINT_ALU = 1'b0,
        HINT_MEM = 1'b1
    } hint_e;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wis_warp_slot.sv
module wis_warp_slot
    import wis_pkg::*;
#(
    parameter int MEM_LAT = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_hit_i,
    input  logic ret_hit_i,
    input  logic issue_hit_i,
    input  logic mem_hint_i,
    output logic resident_o,
    output logic ready_o
);
    localparam int CW = $clog2(MEM_LAT + 1);

    typedef struct packed {
        logic          res;
        logic [CW-1:0] cnt;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ret_hit_i) begin
            s_d.res = 1'b0;
            s_d.cnt = '0;
        end else if (act_hit_i && !s_q.res) begin
            s_d.res = 1'b1;
            s_d.cnt = '0;
        end else if (issue_hit_i && (hint_e'(mem_hint_i) == HINT_MEM)) begin
            s_d.cnt = CW'(MEM_LAT);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign resident_o = s_q.res;
    assign ready_o    = s_q.res && (s_q.cnt == '0);

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WARPS = 32,
    parameter int IDW       = 5
) (
    input  logic [NUM_WARPS-1:0] req_i,
    input  logic [IDW-1:0]       last_i,
    output logic                 valid_o,
    output logic [IDW-1:0]       id_o
);
    always_comb begin
        int idx;
        valid_o = 1'b0;
        id_o    = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            idx = int'(last_i) + k;
            if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
            if (!valid_o && req_i[idx]) begin
                valid_o = 1'b1;
                id_o    = idx[IDW-1:0];
            end
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 32,
    parameter int MEM_LAT   = 400,
    parameter int IDW       = idx_bits(NUM_WARPS),
    parameter int OCW       = $clog2(NUM_WARPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_valid,
    input  logic [IDW-1:0]       act_id,
    input  logic                 ret_valid,
    input  logic [IDW-1:0]       ret_id,
    input  logic [NUM_WARPS-1:0] kind_mem,
    output logic                 issue_valid,
    output logic [IDW-1:0]       issue_id,
    output logic                 stall,
    output logic [OCW-1:0]       occupancy
);
    typedef struct packed {
        logic [IDW-1:0] last;
        logic [OCW-1:0] occ;
    } top_t;

    top_t t_d, t_q;

    logic [NUM_WARPS-1:0] slot_res;
    logic [NUM_WARPS-1:0] slot_rdy;
    logic [NUM_WARPS-1:0] ret_mask;
    logic [NUM_WARPS-1:0] act_mask;
    logic [NUM_WARPS-1:0] iss_mask;
    logic                 pick_v;
    logic [IDW-1:0]       pick_id;

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
        assign ret_mask[g] = ret_valid && (int'(ret_id) == g);
        assign act_mask[g] = act_valid && (int'(act_id) == g);
        assign iss_mask[g] = pick_v && (int'(pick_id) == g);

        wis_warp_slot #(.MEM_LAT(MEM_LAT)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_hit_i  (act_mask[g]),
            .ret_hit_i  (ret_mask[g]),
            .issue_hit_i(iss_mask[g]),
            .mem_hint_i (kind_mem[g]),
            .resident_o (slot_res[g]),
            .ready_o    (slot_rdy[g])
        );
    end

    wis_rr_pick #(.NUM_WARPS(NUM_WARPS), .IDW(IDW)) u_pick (
        .req_i  (slot_rdy & ~ret_mask),
        .last_i (t_q.last),
        .valid_o(pick_v),
        .id_o   (pick_id)
    );

    logic act_eff, ret_eff;
    assign act_eff = |(act_mask & ~slot_res & ~ret_mask);
    assign ret_eff = |(ret_mask & slot_res);

    always_comb begin
        t_d = t_q;
        if (pick_v) t_d.last = pick_id;
        t_d.occ = t_q.occ + {{(OCW-1){1'b0}}, act_eff} - {{(OCW-1){1'b0}}, ret_eff};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.last <= IDW'(NUM_WARPS - 1);
            t_q.occ  <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign issue_valid = pick_v;
    assign issue_id    = pick_id;
    assign occupancy   = t_q.occ;
    assign stall       = (t_q.occ != '0) && !pick_v;

endmodule

// File: rtl/wis_sched_chk.sv
module wis_sched_chk #(
    parameter int NUM_WARPS = 32,
    parameter int IDW       = 5,
    parameter int OCW       = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic [IDW-1:0]       issue_id,
    input logic                 stall,
    input logic [OCW-1:0]       occupancy,
    input logic [NUM_WARPS-1:0] slot_res,
    input logic                 ret_valid,
    input logic [IDW-1:0]       ret_id,
    input logic [NUM_WARPS-1:0] kind_mem
);
    // R1
    issue_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> slot_res[issue_id]);

    // R5
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && stall));

    // R5
    stall_needs_warp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (occupancy != '0));

    // R6
    occ_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(occupancy) == $countones(slot_res));

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && kind_mem[issue_id]) |=> !(issue_valid && issue_id == $past(issue_id)));

    // R8
    ret_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !(issue_valid && issue_id == ret_id));

    // R8
    ret_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && int'(ret_id) < NUM_WARPS) |=> !slot_res[$past(ret_id)]);

endmodule

bind warp_issue_sched wis_sched_chk #(
    .NUM_WARPS(NUM_WARPS),
    .IDW      (IDW),
    .OCW      (OCW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .issue_id   (issue_id),
    .stall      (stall),
    .occupancy  (occupancy),
    .slot_res   (slot_res),
    .ret_valid  (ret_valid),
    .ret_id     (ret_id),
    .kind_mem   (kind_mem)
);

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;
    localparam int NW  = 8;
    localparam int LAT = 12;
    localparam int IDW = 3;
    localparam int OCW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_valid = 1'b0;
    logic [IDW-1:0] act_id = '0;
    logic ret_valid = 1'b0;
    logic [IDW-1:0] ret_id = '0;
    logic [NW-1:0] kind_mem = '0;
    logic issue_valid, stall;
    logic [IDW-1:0] issue_id;
    logic [OCW-1:0] occupancy;

    always #2.5 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .MEM_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_id(act_id),
        .ret_valid(ret_valid), .ret_id(ret_id), .kind_mem(kind_mem),
        .issue_valid(issue_valid), .issue_id(issue_id), .stall(stall),
        .occupancy(occupancy)
    );

    typedef struct {
        bit v;
        int id;
        bit st;
        int occ;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int n_cmp = 0;
    int n_bad = 0;

    bit m_res[NW];
    int m_cnt[NW];
    int m_last = NW - 1;
    int m_occ  = 0;

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops one expectation per cycle and compares the outputs
    initial begin
        forever begin
            @(chk_ev);
            #1;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                cmp("R1 issue_valid", int'(issue_valid), int'(e.v));
                if (e.v) cmp("R2 issue_id", int'(issue_id), e.id);
                cmp("R5 stall", int'(stall), int'(e.st));
                cmp("R6 occupancy", int'(occupancy), e.occ);
            end
        end
    end

    // Driver: sets inputs, pushes the expected outputs, advances the model
    task automatic step(input bit av, input int aid, input bit rv, input int rid,
                        input logic [NW-1:0] mem);
        exp_t e;
        bit act_eff, ret_eff;
        @(negedge clk);
        act_valid = av; act_id = IDW'(aid);
        ret_valid = rv; ret_id = IDW'(rid);
        kind_mem  = mem;
        e.v = 0; e.id = 0;
        for (int k = 1; k <= NW; k++) begin
            int w;
            w = (m_last + k) % NW;
            if (!e.v && m_res[w] && m_cnt[w] == 0 && !(rv && rid == w)) begin
                e.v = 1; e.id = w;
            end
        end
        e.st  = (m_occ != 0) && !e.v;
        e.occ = m_occ;
        q.push_back(e);
        -> chk_ev;
        act_eff = av && !m_res[aid] && !(rv && rid == aid);
        ret_eff = rv && m_res[rid];
        for (int w = 0; w < NW; w++) begin
            if (rv && rid == w) begin
                m_res[w] = 0; m_cnt[w] = 0;
            end else if (av && aid == w && !m_res[w]) begin
                m_res[w] = 1; m_cnt[w] = 0;
            end else if (e.v && e.id == w && mem[w]) begin
                m_cnt[w] = LAT;
            end else if (m_cnt[w] > 0) begin
                m_cnt[w]--;
            end
        end
        m_occ = m_occ + int'(act_eff) - int'(ret_eff);
        if (e.v) m_last = e.id;
    endtask

    task automatic idle(input int n, input logic [NW-1:0] mem);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, mem);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int w = 0; w < NW; w++) begin m_res[w] = 0; m_cnt[w] = 0; end
        // R10: outputs quiet while reset is held
        repeat (3) @(negedge clk);
        #1;
        cmp("R10 issue_valid in reset", int'(issue_valid), 0);
        cmp("R10 stall in reset", int'(stall), 0);
        cmp("R10 occupancy in reset", int'(occupancy), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: empty pool after reset, no stall
        idle(3, '0);
        // R7 R2 R4: activate four warps, ALU hints, round-robin from slot 0
        for (int w = 0; w < 4; w++) step(1, w, 0, 0, '0);
        idle(8, '0);
        // R3 R5: all memory hints, each warp waits LAT cycles, stall in between
        idle(40, '1);
        // R8: retire warp 1, then retire empty slot 6 (no effect)
        step(0, 0, 1, 1, '0);
        idle(3, '0);
        step(0, 0, 1, 6, '0);
        idle(3, '0);
        // R7: re-activate resident warp 0 during its memory wait (no effect)
        idle(2, 8'b0000_0001);
        step(1, 0, 0, 0, 8'b0000_0001);
        idle(16, 8'b0000_0001);
        // R9: activate and retire slot 2 in the same cycle
        step(1, 2, 1, 2, '0);
        idle(3, '0);
        step(1, 5, 1, 5, '0);
        idle(3, '0);
        // R6: fill all slots, mixed hints
        for (int w = 0; w < NW; w++) step(1, w, 0, 0, 8'b1010_0101);
        idle(40, 8'b1010_0101);
        // R8 R5: retire every warp, pool drains to empty
        for (int w = 0; w < NW; w++) step(0, 0, 1, w, 8'b0101_1010);
        idle(4, '0);
        @(negedge clk);
        #2;
        finish_run();
    end

endmodule